// File: doc/BRIEF.md
# Asynchronous Strobe-Cycle Bus Master

This block runs single and chained read and write cycles on an asynchronous external bus. Each cycle has three phases. In the setup phase the chip enable, address and direction are driven. In the strobe phase the read or write strobe is held low. In the hold phase the address and enable stay valid after the strobe is released. The length of each phase, in clock cycles, comes from a 32-bit space control word that has separate read and write fields. A slave can stretch the strobe phase by holding its ready input low.

Local logic issues requests over a valid/ready channel that carries the address, the direction and the write data. A request is accepted only in a cycle where both `req_valid` and `req_ready` are high. The requester must keep the request fields stable until that cycle. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse, and `rsp_rdata` must be taken in that cycle. During reads the output enable is held low, so a slave can treat it as an active-low read indicator. During writes a data-drive enable qualifies `bus_dout`.

Top module: `strobe_bus_master`

## Requirements
- R1: After reset, and at once when reset is asserted mid-cycle, `bus_ce_n`, `bus_re_n`, `bus_we_n` and `bus_oe_n` are high, `bus_wr_en` and `rsp_valid` are low, and `req_ready` is high when the memory type field is valid.
- R2: The phase lengths come from the `cfg_space` fields of the accepted request's direction. Writes use setup [31:28], strobe [27:22] and hold [21:20]. Reads use setup [19:16], strobe [13:8] and hold [1:0]. The other direction's fields and bits [15:14] and [3:2] have no effect.
- R3: Requests are accepted only while `cfg_space[7:4]` equals 4'b0010. With any other code `req_ready` stays low and the bus stays idle. Once the code becomes valid, a pending request proceeds.
- R4: `bus_ce_n` is low and `bus_addr` is stable for exactly the setup count before the strobe falls and for exactly the hold count after it rises.
- R5: With the slave ready, the strobe is low for exactly the programmed strobe count. A setup, strobe or hold field of zero counts as one cycle.
- R6: Ready is sampled only from the last cycle of the programmed strobe count onward. While it is low there, the strobe stays low. The strobe is released at the first edge that sees `bus_rdy` high.
- R7: Read data is captured from `bus_din` at the edge that releases the strobe. It is presented on `rsp_rdata` while `rsp_valid` is high, and `rsp_valid` is high only in the last hold cycle, for one cycle.
- R8: For a write, `bus_wr_en` is high and `bus_dout` carries the request data for the whole cycle, including every cycle the write strobe is low.
- R9: `bus_oe_n` is low in every cycle of a read (setup, strobe and hold) and high throughout writes. The read and write strobes are never low together.
- R10: `req_ready` is high in the last hold cycle. A request accepted there enters setup in the next cycle, with no idle cycle between.
- R11: While a cycle is in progress, outside its last hold cycle, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_space | input | 32 | Space control word: phase fields and memory type |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle done pulse in the last hold cycle |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_ce_n | output | 1 | Active-low chip enable |
| bus_addr | output | ADDR_W | Address/select lines |
| bus_re_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_oe_n | output | 1 | Active-low output enable, low during reads |
| bus_wr_en | output | 1 | Data-drive enable for bus_dout during writes |
| bus_dout | output | DATA_W | Write data toward the bus |
| bus_din | input | DATA_W | Read data from the bus |
| bus_rdy | input | 1 | Slave ready, low stretches the strobe |

## Verification
A wrong phase counter or a wrong field selection shows up as a miscounted setup, strobe or hold run on `bus_ce_n` and the strobes. This is visible within the same transaction, and at the latest at its done pulse. A wrong phase state, such as a missed ready wait or a skipped hold, moves `rsp_valid` by at least one cycle and corrupts `rsp_rdata`. It can also break the no-gap chaining, which shows as `bus_ce_n` rising for one cycle after the done pulse. A wrong direction register shows on the first cycle of setup, because `bus_oe_n` and `bus_wr_en` take the wrong levels.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int CFG_W = 32;
  localparam int SU_W  = 4;
  localparam int ST_W  = 6;
  localparam int HD_W  = 2;
  localparam int CNT_W = (ST_W > SU_W) ? ST_W : SU_W;
  localparam logic [3:0] MT_ASYNC = 4'b0010;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_t;

  // Phase lengths minus one, zero fields already promoted to one cycle
  typedef struct packed {
    logic [SU_W-1:0] su_last;
    logic [ST_W-1:0] st_last;
    logic [HD_W-1:0] hd_last;
  } timing_t;
endpackage

// File: rtl/sbm_cfg_decode.sv
module sbm_cfg_decode
  import sbm_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic             is_write,
  output timing_t          tim,
  output logic             type_ok
);
  logic [SU_W-1:0] su_raw;
  logic [ST_W-1:0] st_raw;
  logic [HD_W-1:0] hd_raw;
  logic            unused_cfg_bits;

  always_comb begin
    if (is_write) begin
      su_raw = cfg[31:28];
      st_raw = cfg[27:22];
      hd_raw = cfg[21:20];
    end else begin
      su_raw = cfg[19:16];
      st_raw = cfg[13:8];
      hd_raw = cfg[1:0];
    end
    tim.su_last = (su_raw == '0) ? '0 : su_raw - SU_W'(1);
    tim.st_last = (st_raw == '0) ? '0 : st_raw - ST_W'(1);
    tim.hd_last = (hd_raw == '0) ? '0 : hd_raw - HD_W'(1);
  end

  assign type_ok         = (cfg[7:4] == MT_ASYNC);
  assign unused_cfg_bits = ^{cfg[15:14], cfg[3:2]};
endmodule

// File: rtl/sbm_phase_ctrl.sv
module sbm_phase_ctrl
  import sbm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept,
  input  timing_t tim_new,
  input  logic    rdy,
  output phase_t  phase,
  output logic    last
);
  timing_t          tim_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      tim_q <= '0;
    end else begin
      if (accept) tim_q <= tim_new;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase <= PH_SETUP;
            cnt   <= CNT_W'(tim_new.su_last);
          end
        end
        PH_SETUP: begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else begin
            phase <= PH_STROBE;
            cnt   <= CNT_W'(tim_q.st_last);
          end
        end
        PH_STROBE: begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else if (rdy) begin
            phase <= PH_HOLD;
            cnt   <= CNT_W'(tim_q.hd_last);
          end
        end
        PH_HOLD: begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else if (accept) begin
            phase <= PH_SETUP;
            cnt   <= CNT_W'(tim_new.su_last);
          end else begin
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sbm_datapath.sv
module sbm_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic              dir_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        dir_q   <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture && !dir_q) rdata_q <= bus_din;
    end
  end
endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_space,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_ce_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_re_n,
  output logic              bus_we_n,
  output logic              bus_oe_n,
  output logic              bus_wr_en,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_rdy
);
  timing_t tim_new;
  logic    type_ok;
  phase_t  phase;
  logic    last;
  logic    accept;
  logic    capture;
  logic    dir_q;
  logic    busy;
  logic    in_strobe;

  sbm_cfg_decode u_dec (
    .cfg      (cfg_space),
    .is_write (req_write),
    .tim      (tim_new),
    .type_ok  (type_ok)
  );

  sbm_phase_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .tim_new (tim_new),
    .rdy     (bus_rdy),
    .phase   (phase),
    .last    (last)
  );

  sbm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bus_din   (bus_din),
    .dir_q     (dir_q),
    .addr_q    (bus_addr),
    .wdata_q   (bus_dout),
    .rdata_q   (rsp_rdata)
  );

  assign busy      = (phase != PH_IDLE);
  assign in_strobe = (phase == PH_STROBE);
  assign req_ready = type_ok && (!busy || (phase == PH_HOLD && last));
  assign accept    = req_valid && req_ready;
  assign capture   = in_strobe && last && bus_rdy;
  assign rsp_valid = (phase == PH_HOLD) && last;

  assign bus_ce_n  = !busy;
  assign bus_re_n  = !(in_strobe && !dir_q);
  assign bus_we_n  = !(in_strobe && dir_q);
  assign bus_oe_n  = !(busy && !dir_q);
  assign bus_wr_en = busy && dir_q;
endmodule

// File: rtl/sbm_chk.sv
module sbm_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_space,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bus_ce_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_re_n,
  input logic              bus_we_n,
  input logic              bus_oe_n,
  input logic              bus_wr_en,
  input logic              bus_rdy
);
  // R3
  bad_type_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_space[7:4] != 4'b0010 && bus_ce_n) |=> bus_ce_n);

  // R4
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_re_n) || $fell(bus_we_n)) |-> $past(!bus_ce_n));

  // R4
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_re_n) || $rose(bus_we_n)) |-> !bus_ce_n);

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce_n && $past(!bus_ce_n) && !$past(rsp_valid)) |-> $stable(bus_addr));

  // R6
  rdy_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rdy && (!bus_re_n || !bus_we_n)) |=> (!bus_re_n || !bus_we_n));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  wdrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> bus_wr_en);

  // R9
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re_n |-> (!bus_oe_n && !bus_wr_en));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!bus_re_n, !bus_we_n}));

  // R10
  chain_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cfg_space[7:4] == 4'b0010) |-> req_ready);

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce_n && !rsp_valid) |-> !req_ready);
endmodule

bind strobe_bus_master sbm_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_strobe_bus_master.sv
module sim_strobe_bus_master;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       cfg_space = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic              bus_ce_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_re_n;
  logic              bus_we_n;
  logic              bus_oe_n;
  logic              bus_wr_en;
  logic [DATA_W-1:0] bus_dout;
  logic [DATA_W-1:0] bus_din;
  logic              bus_rdy = 1'b1;

  int errors = 0;
  int checks = 0;
  int slv_min = 1;
  int slv_wait = 0;
  int lowcnt = 0;
  logic [31:0] wcap = '0;

  always #5 clk = ~clk;

  strobe_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (.*);

  // Slave model: read data is a function of the address; ready held low for slv_wait extra cycles
  assign bus_din = !bus_re_n ? {16'hC0DE, bus_addr} : 32'hFFFF_FFFF;

  always @(negedge clk) begin
    if (!bus_re_n || !bus_we_n) lowcnt = lowcnt + 1;
    else lowcnt = 0;
    bus_rdy = (lowcnt == 0) || (lowcnt >= slv_min + slv_wait);
    if (!bus_we_n && bus_wr_en) wcap = bus_dout;
  end

  // {write, setup, strobe, hold, ready-wait, expected cycles from accept to done}
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 4'd2,  6'd6,  2'd3, 4'd0, 8'd11},
    {1'b1, 4'd2,  6'd6,  2'd3, 4'd0, 8'd11},
    {1'b0, 4'd2,  6'd7,  2'd3, 4'd0, 8'd12},
    {1'b1, 4'd1,  6'd1,  2'd1, 4'd0, 8'd3},
    {1'b0, 4'd0,  6'd0,  2'd0, 4'd0, 8'd3},
    {1'b1, 4'd15, 6'd63, 2'd3, 4'd0, 8'd81},
    {1'b0, 4'd3,  6'd4,  2'd2, 4'd5, 8'd14},
    {1'b1, 4'd2,  6'd6,  2'd3, 4'd3, 8'd14},
    {1'b1, 4'd0,  6'd5,  2'd0, 4'd2, 8'd9},
    {1'b0, 4'd4,  6'd1,  2'd1, 4'd3, 8'd9}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input logic wr, input int su, input int st,
                                         input int hd, input logic [3:0] mt);
    logic [31:0] c;
    c = '0;
    if (wr) begin
      c[31:28] = su[3:0]; c[27:22] = st[5:0]; c[21:20] = hd[1:0];
      c[19:16] = 4'd5;    c[13:8]  = 6'd9;    c[1:0]   = 2'd2;
    end else begin
      c[19:16] = su[3:0]; c[13:8]  = st[5:0]; c[1:0]   = hd[1:0];
      c[31:28] = 4'd6;    c[27:22] = 6'd10;   c[21:20] = 2'd1;
    end
    c[15:14] = 2'b11;
    c[3:2]   = 2'b11;
    c[7:4]   = mt;
    return c;
  endfunction

  function automatic int at_least_one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run_txn(input logic wr, input int su, input int st, input int hd,
                         input int wt, input int lat, input logic [15:0] a,
                         input logic [31:0] d);
    int cyc = 0, n_su = 0, n_st = 0, n_hd = 0, n_oe = 0, n_busy = 0;
    bit seen_st = 0, done = 0;
    logic [31:0] rd = '0;
    @(negedge clk);
    cfg_space = mk_cfg(wr, su, st, hd, 4'b0010);
    slv_min = at_least_one(st);
    slv_wait = wt;
    req_addr = a; req_wdata = d; req_write = wr; req_valid = 1'b1;
    wcap = '0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (!bus_ce_n) begin
        if (!bus_re_n || !bus_we_n) begin n_st++; seen_st = 1; end
        else if (!seen_st) n_su++;
        else n_hd++;
        if (!bus_oe_n) n_oe++;
        if (req_ready && !rsp_valid) n_busy++;
      end
      if (rsp_valid) begin done = 1; rd = rsp_rdata; end
    end
    chk("R2 R5 R6 latency", cyc, lat);
    chk("R4 setup cycles", n_su, at_least_one(su));
    chk("R5 R6 strobe cycles", n_st, at_least_one(st) + wt);
    chk("R4 hold cycles", n_hd, at_least_one(hd));
    chk("R9 oe cycles", n_oe, wr ? 0 : lat);
    chk("R11 ready while busy", n_busy, 0);
    if (wr) chk("R8 write data", wcap, d);
    else    chk("R7 read data", rd, {16'hC0DE, a});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int d1 = 0, d2 = 0, cyc = 0;
    logic [31:0] rd1 = '0, rd2 = '0;
    cfg_space = mk_cfg(1'b0, 2, 6, 3, 4'b0010);
    repeat (3) @(negedge clk);
    // R1: idle state after reset
    chk("R1 idle outputs in reset", {26'd0, bus_ce_n, bus_re_n, bus_we_n, bus_oe_n, bus_wr_en, rsp_valid}, 32'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle outputs after reset", {26'd0, bus_ce_n, bus_re_n, bus_we_n, bus_oe_n, bus_wr_en, rsp_valid}, 32'b111100);
    chk("R1 ready after reset", req_ready, 1);

    for (int i = 0; i < 10; i++) begin
      run_txn(VEC[i][24], int'(VEC[i][23:20]), int'(VEC[i][19:14]), int'(VEC[i][13:12]),
              int'(VEC[i][11:8]), int'(VEC[i][7:0]), 16'h1000 + 16'(i * 16'h0111),
              32'h5A00_0000 ^ (i * 32'h0013_0507));
    end

    // R3: bad memory type blocks the engine, then a valid code releases the pending request
    @(negedge clk);
    cfg_space = mk_cfg(1'b0, 2, 6, 3, 4'b0011);
    slv_min = 6; slv_wait = 0;
    req_addr = 16'h3C3C; req_write = 1'b0; req_valid = 1'b1;
    begin
      int n_ce = 0, n_rdy = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (!bus_ce_n) n_ce++;
        if (req_ready) n_rdy++;
      end
      chk("R3 bus idle on bad type", n_ce, 0);
      chk("R3 ready low on bad type", n_rdy, 0);
    end
    cfg_space = mk_cfg(1'b0, 2, 6, 3, 4'b0010);
    cyc = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && cyc < 400) begin @(negedge clk); cyc++; end
    chk("R3 resumed read data", rsp_rdata, {16'hC0DE, 16'h3C3C});

    // R10: chained reads with no idle cycle
    @(negedge clk);
    req_addr = 16'hAAAA; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    cyc = 1;
    req_addr = 16'h5555;
    while (!rsp_valid && cyc < 400) begin @(negedge clk); cyc++; end
    d1 = cyc; rd1 = rsp_rdata;
    chk("R10 ready in last hold", req_ready, 1);
    @(negedge clk);
    cyc++;
    req_valid = 1'b0;
    chk("R10 no idle cycle between", {bus_ce_n, bus_re_n}, 2'b01);
    while (!rsp_valid && cyc < 400) begin @(negedge clk); cyc++; end
    d2 = cyc; rd2 = rsp_rdata;
    chk("R7 first chained data", rd1, {16'hC0DE, 16'hAAAA});
    chk("R7 second chained data", rd2, {16'hC0DE, 16'h5555});
    chk("R10 done spacing", d2 - d1, 11);

    // R1: reset asserted in the middle of a strobe
    @(negedge clk);
    req_addr = 16'h0F0F; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 in strobe before reset", bus_re_n, 0);
    rst_n = 1'b0;
    #1;
    chk("R1 idle outputs on mid-cycle reset", {26'd0, bus_ce_n, bus_re_n, bus_we_n, bus_oe_n, bus_wr_en, rsp_valid}, 32'b111100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule